// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Modes

This block is the receive half of one asynchronous serial channel. A 16x oversampling enable paces a sampler that finds each start bit by confirming the line is still low half a bit after the falling edge, then takes every following bit at its centre. Mode fields set the character length and the parity format. Each finished character goes into a three-entry FIFO together with its parity and framing flags.

Two reporting styles are available. In per-character mode the error outputs follow the oldest entry of the FIFO. In block mode they show the OR of every stored character since the last clear, and they stay set until an explicit error-clear command. The receiver can request an interrupt when data is waiting or only when the FIFO is full. It can also drop its ready-to-send output while the FIFO is full, so the far end pauses.

Top module: `uart_rx_channel`

## Requirements
- R1: After `rst`, or a single-cycle `cmd_reset`, the FIFO is empty, all error outputs are 0, the receiver is disabled and `rts_on` is 1.
- R2: A low level seen on a `tick16` cycle starts a frame only if the line is still low 8 ticks later. If it is high at that point the event is ignored and nothing is stored.
- R3: `cfg_len` sets the data length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits. Data arrives LSB first, and unused upper bits of `rd_data` read 0.
- R4: `cfg_par` selects the parity format. 00 = checked parity, even when `cfg_par_odd`=0 and odd when 1. 01 = forced parity, where the bit must equal `cfg_par_odd`. 10 = no parity bit, and the flag is 0. 11 = multidrop, where the received parity bit is reported in the parity flag without being checked.
- R5: A character whose stop-bit centre sample is low carries a framing error.
- R6: The FIFO holds 3 characters, oldest first. `rd_ready` shows it is not empty, `fifo_full` shows it holds 3, a `rd_pop` pulse removes the oldest, and a pop while empty has no effect.
- R7: A character that completes while the FIFO holds 3 is discarded and sets `err_overrun`. That flag stays set until `cmd_err_clr` or a reset.
- R8: With `cfg_err_block`=0, `err_parity` and `err_framing` are the flags of the oldest stored character, or 0 when the FIFO is empty.
- R9: With `cfg_err_block`=1, `err_parity` and `err_framing` are the OR of every character stored since the last clear. Popping does not clear them; only `cmd_err_clr` or a reset does.
- R10: `irq` equals `rd_ready` when `cfg_irq_full`=0 and equals `fifo_full` when `cfg_irq_full`=1.
- R11: With `cfg_rts_flow`=1, `rts_on` is 0 while the FIFO is full and returns to 1 once an entry is popped. With `cfg_rts_flow`=0 it is always 1.
- R12: `cmd_enable` and `cmd_disable` switch reception on and off. A disabled receiver ignores the line. Commands are single-cycle pulses, one at a time, spaced at least 3 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data length select |
| cfg_par | input | 2 | Parity format select |
| cfg_par_odd | input | 1 | Odd parity / forced bit value |
| cfg_err_block | input | 1 | 1 = block error reporting |
| cfg_irq_full | input | 1 | 1 = interrupt on FIFO full |
| cfg_rts_flow | input | 1 | 1 = RTS follows FIFO space |
| cmd_enable | input | 1 | Enable receiver pulse |
| cmd_disable | input | 1 | Disable receiver pulse |
| cmd_err_clr | input | 1 | Clear sticky error pulse |
| cmd_reset | input | 1 | Receiver reset pulse |
| rd_pop | input | 1 | Remove oldest character |
| rd_data | output | 8 | Oldest character |
| rd_ready | output | 1 | FIFO not empty |
| fifo_full | output | 1 | FIFO holds 3 characters |
| err_parity | output | 1 | Parity / address flag |
| err_framing | output | 1 | Framing error |
| err_overrun | output | 1 | Overrun error |
| irq | output | 1 | Receive interrupt request |
| rts_on | output | 1 | Ready-to-send, active high |

## Verification
The assertions assume that the four command inputs are single-cycle pulses and never more than one is high at a time. They also assume the configuration inputs change only while the line is idle between frames. The bench drives every command through a task that holds the pulse for one clock and then waits three more clocks. It changes mode fields only after a frame's idle gap, and it places pops between frames so a pop never meets a character completing in the same cycle.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        PAR_CHECKED   = 2'b00,
        PAR_FORCED    = 2'b01,
        PAR_NONE      = 2'b10,
        PAR_MULTIDROP = 2'b11
    } par_fmt_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       par_flag;
        logic       frm_err;
    } rx_char_t;

    // number of data bits for a length code
    function automatic logic [3:0] data_bits(input logic [1:0] len_code);
        return 4'd5 + {2'b00, len_code};
    endfunction

    // parity flag for a completed character
    function automatic logic parity_flag(input logic [1:0] fmt, input logic odd,
                                         input logic [7:0] d, input logic pbit);
        logic flag;
        case (fmt)
            PAR_CHECKED:   flag = (^d) ^ pbit ^ odd;
            PAR_FORCED:    flag = pbit ^ odd;
            PAR_MULTIDROP: flag = pbit;
            default:       flag = 1'b0;
        endcase
        return flag;
    endfunction

endpackage

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] len_code,
    input  logic [1:0] par_fmt,
    input  logic       par_odd,
    output logic       done,
    output rx_char_t   chr
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] HALF_LAST = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] FULL_LAST = CW'(OVS - 1);

    rx_state_e     state;
    logic [CW-1:0] cnt;
    logic [3:0]    idx;
    logic [7:0]    shreg;
    logic          pbit;
    logic [3:0]    nbits;

    assign nbits = data_bits(len_code);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state <= RX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
            done  <= 1'b0;
            chr   <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!rxd) begin
                            state <= RX_START;
                            cnt   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == HALF_LAST) begin
                            cnt   <= '0;
                            idx   <= '0;
                            shreg <= '0;
                            state <= rxd ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == FULL_LAST) begin
                            cnt             <= '0;
                            shreg[idx[2:0]] <= rxd;
                            idx             <= idx + 4'd1;
                            if (idx == nbits - 4'd1)
                                state <= (par_fmt == PAR_NONE) ? RX_STOP : RX_PAR;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (cnt == FULL_LAST) begin
                            cnt   <= '0;
                            pbit  <= rxd;
                            state <= RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == FULL_LAST) begin
                            cnt          <= '0;
                            done         <= 1'b1;
                            chr.data     <= shreg;
                            chr.frm_err  <= !rxd;
                            chr.par_flag <= parity_flag(par_fmt, par_odd, shreg, pbit);
                            state        <= RX_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    AST_START_CONFIRMED: assert property (@(posedge clk) disable iff (rst)
        (state == RX_DATA && $past(state) == RX_START) |-> !$past(rxd)); // R2

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     flush,
    input  logic     push,
    input  rx_char_t wr_chr,
    input  logic     pop,
    output rx_char_t head,
    output logic     not_empty,
    output logic     full,
    output logic     accepted,
    output logic     dropped
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [NW-1:0] CAP  = NW'(DEPTH);

    rx_char_t      mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [NW-1:0] count;
    logic          do_pop;

    assign full      = (count == CAP);
    assign not_empty = (count != '0);
    assign do_pop    = pop && not_empty;
    assign accepted  = push && !full;
    assign dropped   = push && full;
    assign head      = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (accepted) begin
                mem[wr_ptr] <= wr_chr;
                wr_ptr      <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + NW'(accepted) - NW'(do_pop);
        end
    end

    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst || flush)
        (pop && !push && count == '0) |=> (count == '0)); // R6

    AST_FULL_DISCARD: assert property (@(posedge clk) disable iff (rst || flush)
        (push && !pop && full) |=> full); // R7

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic blk_mode,
    input  logic stored,
    input  logic lost,
    input  logic new_par,
    input  logic new_frm,
    input  logic head_valid,
    input  logic head_par,
    input  logic head_frm,
    output logic err_par,
    output logic err_frm,
    output logic err_ovr
);
    logic acc_par, acc_frm;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_par <= 1'b0;
            acc_frm <= 1'b0;
            err_ovr <= 1'b0;
        end else begin
            if (stored) begin
                acc_par <= acc_par | new_par;
                acc_frm <= acc_frm | new_frm;
            end
            if (lost)
                err_ovr <= 1'b1;
        end
    end

    assign err_par = blk_mode ? acc_par : (head_valid & head_par);
    assign err_frm = blk_mode ? acc_frm : (head_valid & head_frm);

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        (lost && !clr) |=> err_ovr); // R7

    AST_BLOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        (blk_mode && $past(blk_mode) && $past(err_par) && !$past(clr)) |-> err_par); // R9

endmodule

// File: rtl/uart_rx_channel.sv
module uart_rx_channel
    import uart_rx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par,
    input  logic       cfg_par_odd,
    input  logic       cfg_err_block,
    input  logic       cfg_irq_full,
    input  logic       cfg_rts_flow,
    input  logic       cmd_enable,
    input  logic       cmd_disable,
    input  logic       cmd_err_clr,
    input  logic       cmd_reset,
    input  logic       rd_pop,
    output logic [7:0] rd_data,
    output logic       rd_ready,
    output logic       fifo_full,
    output logic       err_parity,
    output logic       err_framing,
    output logic       err_overrun,
    output logic       irq,
    output logic       rts_on
);
    logic     rx_en;
    logic     dfr_done;
    rx_char_t dfr_chr;
    rx_char_t head;
    logic     stored, lost;

    always_ff @(posedge clk) begin
        if (rst || cmd_reset)
            rx_en <= 1'b0;
        else if (cmd_enable)
            rx_en <= 1'b1;
        else if (cmd_disable)
            rx_en <= 1'b0;
    end

    uart_rx_deframer #(.OVS(OVS)) u_deframer (
        .clk      (clk),
        .rst      (rst || cmd_reset),
        .enable   (rx_en),
        .tick     (tick16),
        .rxd      (rxd),
        .len_code (cfg_len),
        .par_fmt  (cfg_par),
        .par_odd  (cfg_par_odd),
        .done     (dfr_done),
        .chr      (dfr_chr)
    );

    uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (cmd_reset),
        .push      (dfr_done),
        .wr_chr    (dfr_chr),
        .pop       (rd_pop),
        .head      (head),
        .not_empty (rd_ready),
        .full      (fifo_full),
        .accepted  (stored),
        .dropped   (lost)
    );

    uart_rx_status u_status (
        .clk        (clk),
        .rst        (rst),
        .clr        (cmd_err_clr || cmd_reset),
        .blk_mode   (cfg_err_block),
        .stored     (stored),
        .lost       (lost),
        .new_par    (dfr_chr.par_flag),
        .new_frm    (dfr_chr.frm_err),
        .head_valid (rd_ready),
        .head_par   (head.par_flag),
        .head_frm   (head.frm_err),
        .err_par    (err_parity),
        .err_frm    (err_framing),
        .err_ovr    (err_overrun)
    );

    assign rd_data = head.data;
    assign irq     = cfg_irq_full ? fifo_full : rd_ready;
    assign rts_on  = !(cfg_rts_flow && fifo_full);

    AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_enable, cmd_disable, cmd_err_clr, cmd_reset})); // R12

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !dfr_done); // R12

endmodule

// File: tb/uart_rx_channel_test.sv
module uart_rx_channel_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'b11;
    logic [1:0] cfg_par = 2'b10;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_err_block = 1'b0;
    logic       cfg_irq_full = 1'b0;
    logic       cfg_rts_flow = 1'b0;
    logic       cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_err_clr = 1'b0, cmd_reset = 1'b0;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic       rd_ready, fifo_full, err_parity, err_framing, err_overrun, irq, rts_on;
    logic [1:0] div = 2'd0;
    logic       tick16;

    always #5 clk = ~clk;
    always @(posedge clk) div <= div + 2'd1;
    assign tick16 = (div == 2'd3);

    uart_rx_channel uut (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_par_odd(cfg_par_odd),
        .cfg_err_block(cfg_err_block), .cfg_irq_full(cfg_irq_full),
        .cfg_rts_flow(cfg_rts_flow), .cmd_enable(cmd_enable),
        .cmd_disable(cmd_disable), .cmd_err_clr(cmd_err_clr),
        .cmd_reset(cmd_reset), .rd_pop(rd_pop), .rd_data(rd_data),
        .rd_ready(rd_ready), .fifo_full(fifo_full), .err_parity(err_parity),
        .err_framing(err_framing), .err_overrun(err_overrun), .irq(irq),
        .rts_on(rts_on)
    );

    typedef struct {
        int d;
        bit pf;
        bit ff;
    } ent_t;

    ent_t q[$];
    bit   m_en = 0, acc_p = 0, acc_f = 0, m_ovr = 0;
    bit   ev_push = 0;
    ent_t ev_ent;
    bit   cmp_on = 0;
    int   n_chk = 0, n_bad = 0;
    bit   finished = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // reference model: updated on each rising edge from the inputs
    always @(posedge clk) begin
        int pre;
        if (rst || cmd_reset) begin
            q.delete();
            acc_p = 0; acc_f = 0; m_ovr = 0; m_en = 0; ev_push = 0;
        end else begin
            if (cmd_enable)  m_en = 1;
            if (cmd_disable) m_en = 0;
            if (cmd_err_clr) begin acc_p = 0; acc_f = 0; m_ovr = 0; end
            pre = q.size();
            if (rd_pop && pre > 0) void'(q.pop_front());
            if (ev_push) begin
                if (pre < 3) begin
                    q.push_back(ev_ent);
                    acc_p = acc_p | ev_ent.pf;
                    acc_f = acc_f | ev_ent.ff;
                end else begin
                    m_ovr = 1;
                end
                ev_push = 0;
            end
        end
    end

    // compare every clock, between edges
    always @(posedge clk) begin
        #3;
        if (cmp_on) begin
            int  n;
            bit  ep, ef, full;
            n    = q.size();
            full = (n == 3);
            ep   = cfg_err_block ? acc_p : (n > 0 && q[0].pf);
            ef   = cfg_err_block ? acc_f : (n > 0 && q[0].ff);
            chk("R6 rd_ready", int'(rd_ready), int'(n > 0));
            chk("R6 fifo_full", int'(fifo_full), int'(full));
            if (n > 0) chk("R3 rd_data", int'(rd_data), q[0].d);
            chk(cfg_err_block ? "R9 err_parity" : "R8 err_parity", int'(err_parity), int'(ep));
            chk(cfg_err_block ? "R9 err_framing" : "R8 err_framing", int'(err_framing), int'(ef));
            chk("R7 err_overrun", int'(err_overrun), int'(m_ovr));
            chk("R10 irq", int'(irq), int'(cfg_irq_full ? full : (n > 0)));
            chk("R11 rts_on", int'(rts_on), int'(cfg_rts_flow ? !full : 1'b1));
        end
    end

    task automatic wait_tick();
        do @(posedge clk); while (!tick16);
        @(negedge clk);
    endtask

    task automatic command(input int which);
        @(negedge clk);
        case (which)
            0: cmd_enable  = 1;
            1: cmd_disable = 1;
            2: cmd_err_clr = 1;
            default: cmd_reset = 1;
        endcase
        @(negedge clk);
        cmd_enable = 0; cmd_disable = 0; cmd_err_clr = 0; cmd_reset = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_pop();
        @(negedge clk);
        rd_pop = 1;
        @(negedge clk);
        rd_pop = 0;
        @(negedge clk);
    endtask

    // send one frame using the current configuration
    task automatic send_frame(input int d, input bit corrupt, input bit adflag, input bit stopv);
        int nb, total, ones, masked;
        bit haspar, pbit, pf;
        bit bits[12];
        nb     = 5 + int'(cfg_len);
        haspar = (cfg_par != 2'b10);
        masked = d & ((1 << nb) - 1);
        ones   = $countones(masked);
        case (cfg_par)
            2'b00:   pbit = ((ones % 2) != 0) ^ cfg_par_odd;
            2'b01:   pbit = cfg_par_odd;
            2'b11:   pbit = adflag;
            default: pbit = 0;
        endcase
        if (corrupt) pbit = !pbit;
        pf = (cfg_par == 2'b11) ? adflag : ((cfg_par == 2'b10) ? 1'b0 : corrupt);
        total = 0;
        bits[total++] = 0;
        for (int i = 0; i < nb; i++) bits[total++] = masked[i];
        if (haspar) bits[total++] = pbit;
        bits[total++] = stopv;
        wait_tick();
        for (int k = 0; k < total; k++) begin
            rxd = bits[k];
            for (int t = 1; t <= 16; t++) begin
                wait_tick();
                if (k == total - 1 && t == 9 && m_en) begin
                    ev_ent.d  = masked;
                    ev_ent.pf = pf;
                    ev_ent.ff = !stopv;
                    ev_push   = 1;
                end
            end
        end
        rxd = 1;
        repeat (24) wait_tick();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk("R1 rd_ready", int'(rd_ready), 0);
        chk("R1 err_parity", int'(err_parity), 0);
        chk("R1 err_overrun", int'(err_overrun), 0);
        chk("R1 rts_on", int'(rts_on), 1);
        cmp_on = 1;

        // R12: disabled receiver ignores the line
        send_frame(8'h3C, 0, 0, 1);
        chk("R12 disabled no data", int'(rd_ready), 0);
        command(0);

        // R3: 8 data bits, no parity
        send_frame(8'hA5, 0, 0, 1);
        chk("R3 8-bit data", int'(rd_data), 8'hA5);
        do_pop();

        // R3/R4: 5 bits, even parity
        cfg_len = 2'b00; cfg_par = 2'b00; cfg_par_odd = 0;
        send_frame(8'hF3, 0, 0, 1);
        chk("R3 5-bit masked", int'(rd_data), 8'h13);
        chk("R4 even ok", int'(err_parity), 0);
        do_pop();
        // R4: 7 bits, odd parity, bad parity bit
        cfg_len = 2'b10; cfg_par_odd = 1;
        send_frame(8'h55, 1, 0, 1);
        chk("R4 odd bad", int'(err_parity), 1);
        do_pop();
        // R4: forced parity, both values
        cfg_len = 2'b01; cfg_par = 2'b01; cfg_par_odd = 1;
        send_frame(8'h2A, 0, 0, 1);
        chk("R4 forced ok", int'(err_parity), 0);
        do_pop();
        cfg_par_odd = 0;
        send_frame(8'h2A, 1, 0, 1);
        chk("R4 forced bad", int'(err_parity), 1);
        do_pop();
        // R4: multidrop reports the address bit
        cfg_len = 2'b11; cfg_par = 2'b11;
        send_frame(8'h81, 0, 1, 1);
        chk("R4 multidrop addr", int'(err_parity), 1);
        do_pop();
        send_frame(8'h18, 0, 0, 1);
        chk("R4 multidrop data", int'(err_parity), 0);
        do_pop();

        // R5: framing error
        cfg_par = 2'b10;
        send_frame(8'h7E, 0, 0, 0);
        chk("R5 framing", int'(err_framing), 1);
        do_pop();
        chk("R8 empty flags", int'(err_framing), 0);

        // R2: short low pulse is not a start bit
        wait_tick();
        rxd = 0;
        repeat (4) wait_tick();
        rxd = 1;
        repeat (24) wait_tick();
        chk("R2 false start", int'(rd_ready), 0);

        // R6/R7/R10/R11: fill and overrun
        cfg_rts_flow = 1; cfg_irq_full = 1;
        send_frame(8'h01, 0, 0, 1);
        chk("R10 irq not full", int'(irq), 0);
        send_frame(8'h02, 0, 0, 1);
        send_frame(8'h03, 0, 0, 1);
        chk("R11 rts low full", int'(rts_on), 0);
        chk("R10 irq full", int'(irq), 1);
        send_frame(8'h04, 0, 0, 1);
        chk("R7 overrun", int'(err_overrun), 1);
        do_pop();
        chk("R11 rts back", int'(rts_on), 1);
        chk("R6 order", int'(rd_data), 8'h02);
        do_pop();
        do_pop();
        do_pop();
        chk("R6 pop empty", int'(rd_ready), 0);
        chk("R7 overrun sticky", int'(err_overrun), 1);
        command(2);
        chk("R7 overrun cleared", int'(err_overrun), 0);

        // R9: block errors survive pops
        cfg_err_block = 1; cfg_rts_flow = 0; cfg_irq_full = 0;
        cfg_par = 2'b00; cfg_par_odd = 0;
        send_frame(8'h66, 1, 0, 1);
        send_frame(8'h11, 0, 0, 1);
        do_pop();
        do_pop();
        chk("R9 sticky parity", int'(err_parity), 1);
        command(2);
        chk("R9 cleared", int'(err_parity), 0);

        // R1: reset command clears everything and disables
        cfg_par = 2'b10;
        send_frame(8'h99, 0, 0, 0);
        command(3);
        chk("R1 cmd flush", int'(rd_ready), 0);
        chk("R1 cmd errors", int'(err_framing), 0);
        send_frame(8'h42, 0, 0, 1);
        chk("R1 disabled after reset", int'(rd_ready), 0);

        // R12: enable then disable
        command(0);
        send_frame(8'h5A, 0, 0, 1);
        chk("R12 enabled", int'(rd_data), 8'h5A);
        do_pop();
        command(1);
        send_frame(8'hC3, 0, 0, 1);
        chk("R12 disabled", int'(rd_ready), 0);

        repeat (5) @(negedge clk);
        summary();
    end

endmodule